// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block collects interrupt requests from a set of maskable sources plus two fixed sources: a non-maskable interrupt and an address-break interrupt. It picks one winner and hands the CPU a single registered request line together with the winner's vector number. Each maskable source has its own enable bit. It also has a level bit that places it in a favoured group or a plain group. Sources in the upper index range belong to a wake-up class: they ignore their level bit and always sit in the plain group.

A global mask bit, shaped like the CPU's interrupt mask flag, shuts out every maskable source while it is 1. The two fixed sources pass even when the mask bit is 1. A request is raised only when the CPU strobes an instruction boundary. It is accepted when the CPU acknowledges it. Acceptance sets the mask bit. A separate clear strobe, standing in for a return from interrupt, drops the mask bit again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A maskable source competes only while both its captured flag and its `src_en` bit are 1. A flagged but disabled source raises nothing, and its flag stays set.
- R2: Among eligible maskable sources, those in the favoured group (level bit 1) win over those in the plain group (level bit 0).
- R3: Within one group, the lowest source index wins.
- R4: While `mask_bit` is 1, only the non-maskable and address-break sources can raise a request. While it is 0, any eligible source can.
- R5: Sources with index at or above `MASK_ONLY_FIRST` (default 6) are always placed in the plain group, whatever their level bit.
- R6: `irq_req` rises only in the cycle after `insn_end` was 1. While a request is pending, further `insn_end` strobes start nothing new.
- R7: Acceptance (`irq_req` and `cpu_ack` both 1) sets `mask_bit` to 1 on the next cycle, and it wins over a `mask_clr` in the same cycle. `mask_clr` alone clears `mask_bit`.
- R8: Vector numbers are assigned as follows: the non-maskable source gets 7, address break gets 8, and maskable source i gets 16+i.
- R9: The non-maskable source outranks address break, and address break outranks all maskable sources. The flag of either fixed source is cleared only by the acceptance of its own vector.
- R10: A rising edge on `src_raw[i]` sets flag i. The flag holds until a `flag_clr[i]` pulse. An edge in the same cycle as a clear leaves the flag set.
- R11: `irq_req` and `irq_vec` hold steady until acknowledge. `irq_req` is 0 in the cycle after acceptance.
- R12: After reset, `irq_req` is 0, all source flags are 0 and `mask_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raw | input | N_SRC | Raw maskable source lines; a rising edge sets the flag |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | N_SRC | Per-source group bit (1 = favoured) |
| flag_clr | input | N_SRC | Write-one-to-clear pulses for the source flags |
| nmi_raw | input | 1 | Non-maskable source; rising edge captured |
| abrk_raw | input | 1 | Address-break source; rising edge captured |
| insn_end | input | 1 | Instruction-boundary strobe from the CPU |
| cpu_ack | input | 1 | CPU acknowledge of the pending request |
| mask_clr | input | 1 | Clears the mask bit (return from handler) |
| irq_req | output | 1 | Registered request to the CPU |
| irq_vec | output | VEC_W | Registered vector number of the pending request |
| mask_bit | output | 1 | Current global mask bit |
| src_flag | output | N_SRC | Captured source flags |

## Verification
The block has two same-cycle collisions to test. The first is acknowledge against `mask_clr`. The bench drives `mask_clr` high in the acknowledge cycle, both in a directed case and at random, and expects `mask_bit` to read 1 afterwards. The second is a fresh rising edge against a write-one-to-clear on the same flag. It is provoked directly, and the bench expects the flag to still read 1 two cycles later. Random trials pair these collisions with mixed enables, levels and fixed-source pulses, and every arbitration outcome is compared with a bench model of the priority rules.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Which kind of requester won arbitration (or is held pending)
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_NMI  = 2'd1,
    WIN_ABRK = 2'd2,
    WIN_SRC  = 2'd3
  } win_kind_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic prev_q;
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= raw[g];
          // a fresh edge outranks a clear in the same cycle
          if (raw[g] && !prev_q) flag_q <= 1'b1;
          else if (clr[g])       flag_q <= 1'b0;
        end
      end
      assign flag[g] = flag_q;
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import prio_irq_pkg::*;
#(
  parameter int N_SRC           = 8,
  parameter int MASK_ONLY_FIRST = 6,
  parameter int IDX_W           = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] flag,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] lvl,
  input  logic             nmi,
  input  logic             abrk,
  input  logic             mask,
  output win_kind_t        kind,
  output logic [IDX_W-1:0] idx
);
  function automatic logic [N_SRC-1:0] lvl_usable();
    logic [N_SRC-1:0] v;
    for (int i = 0; i < N_SRC; i++) v[i] = (i < MASK_ONLY_FIRST);
    return v;
  endfunction

  localparam logic [N_SRC-1:0] LVL_OK = lvl_usable();

  logic [N_SRC-1:0] ok, hi, lo;
  logic             hit_hi, hit_lo;
  logic [IDX_W-1:0] i_hi, i_lo;

  always_comb begin
    ok     = flag & en & {N_SRC{~mask}};
    hi     = ok & lvl & LVL_OK;
    lo     = ok & ~(lvl & LVL_OK);
    hit_hi = 1'b0;
    hit_lo = 1'b0;
    i_hi   = '0;
    i_lo   = '0;
    // scan downward so the lowest index is the last written
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi[i]) begin
        hit_hi = 1'b1;
        i_hi   = IDX_W'(i);
      end
      if (lo[i]) begin
        hit_lo = 1'b1;
        i_lo   = IDX_W'(i);
      end
    end
    kind = WIN_NONE;
    idx  = '0;
    if (nmi)         kind = WIN_NMI;
    else if (abrk)   kind = WIN_ABRK;
    else if (hit_hi) begin
      kind = WIN_SRC;
      idx  = i_hi;
    end else if (hit_lo) begin
      kind = WIN_SRC;
      idx  = i_lo;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC           = 8,
  parameter int VEC_W           = 8,
  parameter int MASK_ONLY_FIRST = 6,
  parameter int VEC_NMI         = 7,
  parameter int VEC_ABRK        = 8,
  parameter int VEC_BASE        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_raw,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic [N_SRC-1:0] flag_clr,
  input  logic             nmi_raw,
  input  logic             abrk_raw,
  input  logic             insn_end,
  input  logic             cpu_ack,
  input  logic             mask_clr,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             mask_bit,
  output logic [N_SRC-1:0] src_flag
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [1:0]       fix_flag;
  logic [1:0]       fix_clr;
  win_kind_t        win_kind;
  win_kind_t        held_kind;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] win_vec;
  logic             accept;

  assign accept  = irq_req & cpu_ack;
  assign fix_clr = {accept && (held_kind == WIN_ABRK),
                    accept && (held_kind == WIN_NMI)};

  irq_flag_bank #(.W(N_SRC)) u_src_flags (
    .clk(clk), .rst(rst), .raw(src_raw), .clr(flag_clr), .flag(src_flag)
  );

  irq_flag_bank #(.W(2)) u_fix_flags (
    .clk(clk), .rst(rst), .raw({abrk_raw, nmi_raw}), .clr(fix_clr), .flag(fix_flag)
  );

  irq_pick #(
    .N_SRC(N_SRC), .MASK_ONLY_FIRST(MASK_ONLY_FIRST), .IDX_W(IDX_W)
  ) u_pick (
    .flag(src_flag), .en(src_en), .lvl(src_lvl),
    .nmi(fix_flag[0]), .abrk(fix_flag[1]), .mask(mask_bit),
    .kind(win_kind), .idx(win_idx)
  );

  always_comb begin
    case (win_kind)
      WIN_NMI:  win_vec = VEC_W'(VEC_NMI);
      WIN_ABRK: win_vec = VEC_W'(VEC_ABRK);
      WIN_SRC:  win_vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      default:  win_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      held_kind <= WIN_NONE;
      mask_bit  <= 1'b1;
    end else begin
      if (accept) begin
        irq_req   <= 1'b0;
        held_kind <= WIN_NONE;
      end else if (!irq_req && insn_end && (win_kind != WIN_NONE)) begin
        irq_req   <= 1'b1;
        irq_vec   <= win_vec;
        held_kind <= win_kind;
      end
      if (accept)        mask_bit <= 1'b1;
      else if (mask_clr) mask_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_NMI  = 7,
  parameter int VEC_ABRK = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] flag_clr,
  input logic             insn_end,
  input logic             cpu_ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             mask_bit,
  input logic [N_SRC-1:0] src_flag
);
  assert_req_on_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(insn_end));

  assert_vec_held_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !cpu_ack) |=> (irq_req && $stable(irq_vec)));

  assert_ack_masks_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && cpu_ack) |=> (mask_bit && !irq_req));

  assert_masked_fixed_only_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_req) && $past(mask_bit)) |->
      ((irq_vec == VEC_W'(VEC_NMI)) || (irq_vec == VEC_W'(VEC_ABRK))));

  assert_flag_kept_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((src_flag & $past(src_flag & ~flag_clr)) == $past(src_flag & ~flag_clr)));
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_NMI(VEC_NMI), .VEC_ABRK(VEC_ABRK)
) u_chk (
  .clk(clk), .rst(rst), .flag_clr(flag_clr), .insn_end(insn_end),
  .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_vec(irq_vec),
  .mask_bit(mask_bit), .src_flag(src_flag)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int N = 8;
  localparam int FIRST_MO = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_raw = '0, src_en = '0, src_lvl = '0, flag_clr = '0;
  logic nmi_raw = 0, abrk_raw = 0, insn_end = 0, cpu_ack = 0, mask_clr = 0;
  logic irq_req, mask_bit;
  logic [7:0] irq_vec;
  logic [N-1:0] src_flag;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [N-1:0] m_flag = '0;
  bit m_nmi = 0, m_abrk = 0, m_mask = 1;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_raw(src_raw), .src_en(src_en), .src_lvl(src_lvl),
    .flag_clr(flag_clr), .nmi_raw(nmi_raw), .abrk_raw(abrk_raw), .insn_end(insn_end),
    .cpu_ack(cpu_ack), .mask_clr(mask_clr), .irq_req(irq_req), .irq_vec(irq_vec),
    .mask_bit(mask_bit), .src_flag(src_flag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // expected vector from the requirements, -1 when nothing may be raised
  function automatic int predict();
    if (m_nmi) return 7;
    if (m_abrk) return 8;
    if (m_mask) return -1;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && src_en[i] && src_lvl[i] && i < FIRST_MO) return 16 + i;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && src_en[i] && (!src_lvl[i] || i >= FIRST_MO)) return 16 + i;
    return -1;
  endfunction

  task automatic raise(logic [N-1:0] m, bit n, bit a);
    src_raw = m; nmi_raw = n; abrk_raw = a;
    tick();
    src_raw = '0; nmi_raw = 0; abrk_raw = 0;
    tick();
    m_flag |= m; m_nmi |= n; m_abrk |= a;
  endtask

  task automatic unmask();
    mask_clr = 1; tick(); mask_clr = 0; m_mask = 0;
  endtask

  task automatic clear_src();
    flag_clr = '1; tick(); flag_clr = '0; m_flag = '0;
    chk(src_flag == '0, "R10 clear", int'(src_flag), 0);
  endtask

  // strobe a boundary, check the outcome, then acknowledge
  task automatic fire(string tag, bit clr_with_ack);
    int e;
    logic [7:0] v0;
    e = predict();
    tick();
    chk(!irq_req, "R6 no request without boundary", int'(irq_req), 0);
    insn_end = 1; tick(); insn_end = 0;
    if (e < 0) begin
      chk(!irq_req, tag, int'(irq_req), 0);
    end else begin
      chk(irq_req && irq_vec == e, tag, irq_req ? int'(irq_vec) : -1, e);
      v0 = irq_vec;
      insn_end = 1; tick(); insn_end = 0;
      chk(irq_req && irq_vec == v0, "R11 hold until ack", int'(irq_vec), int'(v0));
      cpu_ack = 1; mask_clr = clr_with_ack; tick(); cpu_ack = 0; mask_clr = 0;
      chk(mask_bit == 1'b1, "R7 accept sets mask", int'(mask_bit), 1);
      chk(!irq_req, "R11 drop after ack", int'(irq_req), 0);
      m_mask = 1;
      if (e == 7) m_nmi = 0;
      else if (e == 8) m_abrk = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst = 0;
    tick();
    chk(!irq_req && mask_bit && src_flag == '0, "R12 reset state",
        int'({irq_req, mask_bit}), 1);

    // R1: disabled source stays silent but keeps its flag
    src_en = 8'hFB; src_lvl = '0;
    raise(8'h04, 0, 0); unmask();
    fire("R1 disabled source", 0);
    chk(src_flag == 8'h04, "R1 flag kept", int'(src_flag), 4);
    clear_src();

    // R2: favoured group wins over lower index plain source
    src_en = '1; src_lvl = 8'h10;
    raise(8'h12, 0, 0); unmask();
    fire("R2 level-1 first", 0);
    clear_src();

    // R3 and R8: same group, lowest index, vector 16+i
    src_lvl = '0;
    raise(8'h28, 0, 0); unmask();
    fire("R3 R8 order within group", 1);
    clear_src();

    // R5: source 6 ignores its level bit
    src_lvl = 8'hFE;
    raise(8'h41, 0, 0); unmask();
    fire("R5 mask-only class", 0);
    clear_src();

    // R4: mask blocks maskable sources but not address break
    raise(8'h04, 0, 0);
    fire("R4 masked source blocked", 0);
    raise(8'h00, 0, 1);
    fire("R4 abrk passes mask", 0);
    clear_src();

    // R9: NMI ahead of address break, break follows
    raise(8'h00, 1, 1);
    fire("R9 NMI first", 0);
    fire("R9 abrk next", 0);

    // R10: edge and clear in the same cycle
    src_raw = 8'h08; flag_clr = 8'h08; tick();
    src_raw = '0; flag_clr = '0; tick();
    chk(src_flag == 8'h08, "R10 edge beats clear", int'(src_flag), 8);
    m_flag = 8'h08;
    clear_src();

    // R7: mask_clr alone clears
    unmask();
    chk(mask_bit == 1'b0, "R7 mask_clr clears", int'(mask_bit), 0);

    for (int t = 0; t < 250; t++) begin
      src_en  = N'($urandom);
      src_lvl = N'($urandom);
      raise(N'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
      if ($urandom % 4 != 0) unmask();
      fire("R2 R3 R4 R9 random arbitration", $urandom % 2);
      chk(src_flag == m_flag, "R10 flags held", int'(src_flag), int'(m_flag));
      clear_src();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule